// File: doc/BRIEF.md
# Bad-Block-Skipping Image Loader

This block is a sequencer that copies a contiguous image out of NAND flash into a destination buffer. Software or a boot ROM supplies a byte offset into flash and an image size, then pulses `start`. The loader works through the image one erase block at a time. It issues one page-read request at a time. Each request carries the flash page number and the byte offset in the destination buffer where the page data belongs. A separate page reader answers each request with a result: either readable, together with the first two spare-area bytes, or unreadable.

For each block the loader counts the pages that read cleanly, the pages that carry a bad-block marker, and the pages that failed. After the block it makes a decision. A good block is committed, which moves the destination pointer forward and reduces the remaining work. A bad block is skipped, so the next block is loaded into the same destination range. A block that has read errors but no bad-block marker ends the load with an error. Flash command timing is handled outside this block.

Top module: `nand_image_loader`

## Requirements
- R1: On an accepted `start`, the first page requested is `start_offset` divided by `PAGE_BYTES` (2048 by default), rounded down. Its destination offset is 0.
- R2: The image covers `ceil(image_size / PAGE_BYTES)` pages and `ceil(image_size / (PAGE_BYTES*BLOCK_PAGES))` blocks. A size of 0 raises `done` with no read request issued.
- R3: Within one block the loader requests consecutive pages. The number of pages is at most the remaining page count, capped at `BLOCK_PAGES` (64 by default). Each request's destination offset is the block's destination plus `PAGE_BYTES` times the page's index within the block, so it is always page aligned.
- R4: A page is bad-marked when `rsp_ok` is 1 and either `rsp_spare[7:0]` (spare byte 0) or `rsp_spare[15:8]` (spare byte 1) differs from 0xFF. No further page of that block is requested after a bad-marked page.
- R5: A block in which no page reads successfully counts as bad and is skipped without error.
- R6: A block with at least one unreadable page and no bad-marked page ends the load. `error` rises and no further request is issued.
- R7: Only a good block advances the destination pointer. It advances by the smaller of the remaining byte count and the block size. Only a good block reduces the remaining byte, page and block counts. After a bad block, the next block starts at the same destination offset.
- R8: The page number at which each block starts is always `BLOCK_PAGES` past the previous block's start, whether that block was good or bad.
- R9: `done` rises when the remaining block count reaches zero. `done` and `error` are never high together, and both hold until the next accepted `start`. `busy` is high while a load is in progress, and `start` is ignored during that time.
- R10: At most one page read is outstanding at a time. While `rd_valid` is high and `rd_ready` is low, `rd_page` and `rd_dest` hold steady. No new request appears until `rsp_valid` has returned the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load; accepted when not busy |
| start_offset | input | ADDR_W | Byte offset of the image in flash |
| image_size | input | ADDR_W | Image length in bytes |
| rd_valid | output | 1 | Page-read request valid |
| rd_ready | input | 1 | Page reader accepts the request |
| rd_page | output | ADDR_W-log2(PAGE_BYTES) | Flash page number to read |
| rd_dest | output | ADDR_W | Destination byte offset for the page data |
| rsp_valid | input | 1 | Result of the outstanding read is present |
| rsp_ok | input | 1 | 1 = page read successfully, 0 = unreadable |
| rsp_spare | input | 8*MARK_BYTES | Leading spare bytes; byte 0 in bits 7:0 |
| busy | output | 1 | Load in progress |
| done | output | 1 | Load completed |
| error | output | 1 | Load aborted on an unreadable page in an unmarked block |

## Verification
The bench sweeps unaligned and aligned offsets against sizes on both sides of page and block boundaries, including zero. It does this under several fault maps, and compares every request's page and destination with an arithmetic model. A loader that advanced the page number only on good blocks would revisit skipped pages. One that moved the destination on a bad block would leave holes in the buffer. Fault maps mix marked and unreadable pages in one block: treating an all-unreadable block as fatal, or a marked block with errors as fatal, shows up as a wrong `error`. Continuing to read after a marker shows up as an extra request. Marker placement alternates between spare byte 0 and byte 1, so a check of only one byte misses pages.

// File: rtl/nand_ldr_pkg.sv
package nand_ldr_pkg;

    typedef enum logic [2:0] {
        LS_IDLE,
        LS_SETUP,
        LS_ISSUE,
        LS_WAIT,
        LS_EVAL,
        LS_DONE,
        LS_FAIL
    } ldr_state_e;

endpackage

// File: rtl/nand_ldr_geom.sv
// Converts the byte offset and size of an image into page and block terms.
module nand_ldr_geom #(
    parameter int ADDR_W      = 32,
    parameter int PAGE_BYTES  = 2048,
    parameter int BLOCK_PAGES = 64
) (
    input  logic [ADDR_W-1:0]                              start_offset,
    input  logic [ADDR_W-1:0]                              image_size,
    output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]           first_page,
    output logic [ADDR_W-$clog2(PAGE_BYTES):0]             total_pages,
    output logic [ADDR_W-$clog2(PAGE_BYTES*BLOCK_PAGES):0] total_blocks
);
    localparam int PG_SHIFT    = $clog2(PAGE_BYTES);
    localparam int BLK_SHIFT   = $clog2(PAGE_BYTES * BLOCK_PAGES);
    localparam int BLOCK_BYTES = PAGE_BYTES * BLOCK_PAGES;

    logic [ADDR_W:0] pg_sum;
    logic [ADDR_W:0] blk_sum;

    always_comb begin
        first_page   = start_offset[ADDR_W-1:PG_SHIFT];
        pg_sum       = {1'b0, image_size} + (ADDR_W+1)'(PAGE_BYTES - 1);
        blk_sum      = {1'b0, image_size} + (ADDR_W+1)'(BLOCK_BYTES - 1);
        total_pages  = pg_sum[ADDR_W:PG_SHIFT];
        total_blocks = blk_sum[ADDR_W:BLK_SHIFT];
    end

endmodule

// File: rtl/nand_ldr_marker.sv
// Flags a page whose leading spare bytes are not all erased (0xFF).
module nand_ldr_marker #(
    parameter int MARK_BYTES = 2
) (
    input  logic [8*MARK_BYTES-1:0] spare,
    output logic                    marked
);
    logic [MARK_BYTES-1:0] byte_dirty;

    for (genvar g = 0; g < MARK_BYTES; g++) begin : g_byte
        assign byte_dirty[g] = (spare[8*g +: 8] != 8'hFF);
    end

    assign marked = |byte_dirty;

endmodule

// File: rtl/nand_ldr_tally.sv
// Per-block page outcome counters and the block verdict derived from them.
module nand_ldr_tally #(
    parameter int CNT_W = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic upd,
    input  logic rd_ok,
    input  logic marked,
    output logic blk_bad,
    output logic blk_fatal
);
    typedef struct packed {
        logic [CNT_W-1:0] good;
        logic [CNT_W-1:0] bad;
        logic [CNT_W-1:0] err;
    } tally_t;

    tally_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (clr) begin
            t_d = '0;
        end else if (upd) begin
            if (rd_ok) begin
                t_d.good = t_q.good + CNT_W'(1);
                if (marked) t_d.bad = t_q.bad + CNT_W'(1);
            end else begin
                t_d.err = t_q.err + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    // A block with no readable page is treated as bad.
    assign blk_bad   = (t_q.good == '0) ? (t_q.err != '0) : (t_q.bad != '0);
    assign blk_fatal = (t_q.err != '0) && !blk_bad;

endmodule

// File: rtl/nand_image_loader.sv
module nand_image_loader
    import nand_ldr_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int PAGE_BYTES  = 2048,
    parameter int BLOCK_PAGES = 64,
    parameter int MARK_BYTES  = 2
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    start,
    input  logic [ADDR_W-1:0]                       start_offset,
    input  logic [ADDR_W-1:0]                       image_size,
    output logic                                    rd_valid,
    input  logic                                    rd_ready,
    output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]    rd_page,
    output logic [ADDR_W-1:0]                       rd_dest,
    input  logic                                    rsp_valid,
    input  logic                                    rsp_ok,
    input  logic [8*MARK_BYTES-1:0]                 rsp_spare,
    output logic                                    busy,
    output logic                                    done,
    output logic                                    error
);
    localparam int PG_SHIFT    = $clog2(PAGE_BYTES);
    localparam int BLK_SHIFT   = $clog2(PAGE_BYTES * BLOCK_PAGES);
    localparam int BLOCK_BYTES = PAGE_BYTES * BLOCK_PAGES;
    localparam int PAGE_W      = ADDR_W - PG_SHIFT;
    localparam int PCNT_W      = ADDR_W - PG_SHIFT + 1;
    localparam int BCNT_W      = ADDR_W - BLK_SHIFT + 1;
    localparam int CNT_W       = $clog2(BLOCK_PAGES + 1);

    typedef struct packed {
        ldr_state_e        state;
        logic [PAGE_W-1:0] page;
        logic [ADDR_W-1:0] dest;
        logic [ADDR_W-1:0] bytes_left;
        logic [PCNT_W-1:0] pages_left;
        logic [BCNT_W-1:0] blocks_left;
        logic [PAGE_W-1:0] blk_page;
        logic [ADDR_W-1:0] blk_dst;
        logic [CNT_W-1:0]  blk_left;
        logic [CNT_W-1:0]  blk_span;
    } regs_t;

    regs_t r_d, r_q;

    logic [PAGE_W-1:0] geo_page;
    logic [PCNT_W-1:0] geo_pages;
    logic [BCNT_W-1:0] geo_blocks;
    logic              page_marked;
    logic              tally_clr;
    logic              tally_upd;
    logic              blk_bad;
    logic              blk_fatal;
    logic [CNT_W-1:0]  span_now;
    logic [ADDR_W-1:0] blk_bytes;
    logic              idle_like;

    nand_ldr_geom #(
        .ADDR_W      (ADDR_W),
        .PAGE_BYTES  (PAGE_BYTES),
        .BLOCK_PAGES (BLOCK_PAGES)
    ) geom_i (
        .start_offset (start_offset),
        .image_size   (image_size),
        .first_page   (geo_page),
        .total_pages  (geo_pages),
        .total_blocks (geo_blocks)
    );

    nand_ldr_marker #(
        .MARK_BYTES (MARK_BYTES)
    ) marker_i (
        .spare  (rsp_spare),
        .marked (page_marked)
    );

    nand_ldr_tally #(
        .CNT_W (CNT_W)
    ) tally_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (tally_clr),
        .upd       (tally_upd),
        .rd_ok     (rsp_ok),
        .marked    (page_marked),
        .blk_bad   (blk_bad),
        .blk_fatal (blk_fatal)
    );

    always_comb begin
        span_now  = (r_q.pages_left >= PCNT_W'(BLOCK_PAGES)) ?
                    CNT_W'(BLOCK_PAGES) : r_q.pages_left[CNT_W-1:0];
        blk_bytes = (r_q.bytes_left >= ADDR_W'(BLOCK_BYTES)) ?
                    ADDR_W'(BLOCK_BYTES) : r_q.bytes_left;
        idle_like = (r_q.state == LS_IDLE) || (r_q.state == LS_DONE) ||
                    (r_q.state == LS_FAIL);
        tally_clr = (r_q.state == LS_SETUP);
        tally_upd = (r_q.state == LS_WAIT) && rsp_valid;
    end

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            LS_IDLE, LS_DONE, LS_FAIL: begin
                if (start) begin
                    r_d.page        = geo_page;
                    r_d.dest        = '0;
                    r_d.bytes_left  = image_size;
                    r_d.pages_left  = geo_pages;
                    r_d.blocks_left = geo_blocks;
                    r_d.state       = (geo_blocks == '0) ? LS_DONE : LS_SETUP;
                end
            end
            LS_SETUP: begin
                r_d.blk_page = r_q.page;
                r_d.blk_dst  = r_q.dest;
                r_d.blk_left = span_now;
                r_d.blk_span = span_now;
                r_d.state    = LS_ISSUE;
            end
            LS_ISSUE: begin
                if (rd_ready) r_d.state = LS_WAIT;
            end
            LS_WAIT: begin
                if (rsp_valid) begin
                    r_d.blk_page = r_q.blk_page + PAGE_W'(1);
                    r_d.blk_dst  = r_q.blk_dst + ADDR_W'(PAGE_BYTES);
                    r_d.blk_left = r_q.blk_left - CNT_W'(1);
                    if ((r_q.blk_left == CNT_W'(1)) || (rsp_ok && page_marked))
                        r_d.state = LS_EVAL;
                    else
                        r_d.state = LS_ISSUE;
                end
            end
            LS_EVAL: begin
                if (blk_fatal) begin
                    r_d.state = LS_FAIL;
                end else begin
                    r_d.page = r_q.page + PAGE_W'(BLOCK_PAGES);
                    if (!blk_bad) begin
                        r_d.dest        = r_q.dest + blk_bytes;
                        r_d.bytes_left  = r_q.bytes_left - blk_bytes;
                        r_d.pages_left  = r_q.pages_left - PCNT_W'(r_q.blk_span);
                        r_d.blocks_left = r_q.blocks_left - BCNT_W'(1);
                    end
                    if (!blk_bad && (r_q.blocks_left == BCNT_W'(1)))
                        r_d.state = LS_DONE;
                    else
                        r_d.state = LS_SETUP;
                end
            end
            default: r_d.state = LS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= LS_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_valid = (r_q.state == LS_ISSUE);
    assign rd_page  = r_q.blk_page;
    assign rd_dest  = r_q.blk_dst;
    assign busy     = !idle_like;
    assign done     = (r_q.state == LS_DONE);
    assign error    = (r_q.state == LS_FAIL);

endmodule

// File: rtl/nand_image_loader_chk.sv
module nand_image_loader_chk #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_BYTES = 2048
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic                                 rd_valid,
    input logic                                 rd_ready,
    input logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] rd_page,
    input logic [ADDR_W-1:0]                    rd_dest,
    input logic                                 rsp_valid,
    input logic                                 busy,
    input logic                                 done,
    input logic                                 error
);
    localparam int PG_SHIFT = $clog2(PAGE_BYTES);

    logic in_flight;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     in_flight <= 1'b0;
        else if (rd_valid && rd_ready)  in_flight <= 1'b1;
        else if (rsp_valid)             in_flight <= 1'b0;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_page) && $stable(rd_dest)); // R10

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        in_flight |-> !rd_valid); // R10

    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error)); // R9

    AST_QUIET_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |-> !rd_valid && !busy); // R6

    AST_DEST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_dest[PG_SHIFT-1:0] == '0)); // R3

endmodule

bind nand_image_loader nand_image_loader_chk #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_page   (rd_page),
    .rd_dest   (rd_dest),
    .rsp_valid (rsp_valid),
    .busy      (busy),
    .done      (done),
    .error     (error)
);

// File: tb/nand_image_loader_tb.sv
`timescale 1ns/1ps
module nand_image_loader_tb_top;
    localparam int ADDR_W = 16;
    localparam int PB     = 16;
    localparam int BP     = 4;
    localparam int BB     = PB * BP;
    localparam int PAGE_W = ADDR_W - 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] start_offset = '0;
    logic [ADDR_W-1:0] image_size = '0;
    logic              rd_valid;
    logic              rd_ready = 1'b0;
    logic [PAGE_W-1:0] rd_page;
    logic [ADDR_W-1:0] rd_dest;
    logic              rsp_valid = 1'b0;
    logic              rsp_ok = 1'b0;
    logic [15:0]       rsp_spare = 16'hFFFF;
    logic              busy, done, error;

    int n_chk = 0;
    int n_bad = 0;

    int exp_page [0:255];
    int exp_dst  [0:255];
    int exp_n;
    int exp_fail;

    always #4 clk = ~clk;

    nand_image_loader #(
        .ADDR_W(ADDR_W), .PAGE_BYTES(PB), .BLOCK_PAGES(BP), .MARK_BYTES(2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_offset(start_offset),
        .image_size(image_size), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .rd_page(rd_page), .rd_dest(rd_dest), .rsp_valid(rsp_valid),
        .rsp_ok(rsp_ok), .rsp_spare(rsp_spare), .busy(busy), .done(done),
        .error(error)
    );

    // 0 = readable, 1 = readable with marker, 2 = unreadable
    function automatic int page_stat(int pg, int pat);
        case (pat)
            1: return (pg % 7 == 3) ? 1 : 0;
            2: return (pg % 5 == 2) ? 2 : 0;
            3: return ((pg / BP) % 3 == 1) ? 2 : 0;
            4: return (pg % 6 == 1) ? 2 : ((pg % 9 == 4) ? 1 : 0);
            default: return 0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic build_model(input int off, input int size, input int pat);
        int pg, bl, pl, bk, dst, guard;
        pg = off / PB; bl = size; dst = 0;
        pl = (size + PB - 1) / PB;
        bk = (size + BB - 1) / BB;
        exp_n = 0; exp_fail = 0; guard = 0;
        while (bk > 0 && guard < 64) begin
            int span, good, bad, err, k, st, take;
            span = (pl > BP) ? BP : pl;
            good = 0; bad = 0; err = 0; k = 0;
            while (k < span && bad == 0) begin
                st = page_stat(pg + k, pat);
                exp_page[exp_n] = pg + k;
                exp_dst[exp_n]  = dst + k * PB;
                exp_n++;
                if (st == 2) err++;
                else begin good++; if (st == 1) bad++; end
                k++;
            end
            if (good == 0) bad = err;
            if (err > 0 && bad == 0) begin exp_fail = 1; break; end
            if (bad == 0) begin
                take = (bl > BB) ? BB : bl;
                dst += take; bl -= take; pl -= span; bk--;
            end
            pg += BP;
            guard++;
        end
    endtask

    task automatic run_case(input int off, input int size, input int pat);
        int n, cyc, st;
        build_model(off, size, pat);
        @(negedge clk);
        start_offset = ADDR_W'(off);
        image_size   = ADDR_W'(size);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0; cyc = 0;
        while (!(done || error) && cyc < 5000) begin
            if (rd_valid) begin
                repeat (n % 3) @(negedge clk);
                if (n < exp_n) begin
                    check(int'(rd_page) == exp_page[n], "R1/R3/R8 page", int'(rd_page), exp_page[n]);
                    check(int'(rd_dest) == exp_dst[n], "R3/R7 dest", int'(rd_dest), exp_dst[n]);
                    st = page_stat(int'(rd_page), pat);
                end else begin
                    check(1'b0, "R4/R6 extra request", n, exp_n);
                    st = 0;
                end
                rd_ready = 1'b1;
                @(negedge clk);
                rd_ready = 1'b0;
                repeat (n % 2) @(negedge clk);
                rsp_valid = 1'b1;
                rsp_ok    = (st != 2);
                rsp_spare = (st == 1) ? ((int'(rd_page) % 2 == 0) ? 16'hFF00 : 16'h7FFF) : 16'hFFFF;
                @(negedge clk);
                rsp_valid = 1'b0;
                rsp_spare = 16'hFFFF;
                n++;
            end else begin
                @(negedge clk);
            end
            cyc++;
        end
        check(cyc < 5000, "R9 watchdog", cyc, 0);
        check(n == exp_n, "R2/R4/R5 request count", n, exp_n);
        check(error == (exp_fail == 1), "R5/R6 error flag", int'(error), exp_fail);
        check(done == (exp_fail == 0), "R9 done flag", int'(done), 1 - exp_fail);
        @(negedge clk);
        check(!rd_valid && !busy && (done || error), "R9 hold", int'(busy), 0);
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int offs [5];
        int sizes [7];
        offs  = '{0, 5, 16, 40, 70};
        sizes = '{0, 1, 16, 17, 64, 65, 130};
        repeat (3) @(negedge clk);
        check(!busy && !done && !error && !rd_valid, "R9 reset state", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !error && !rd_valid, "R9 idle after reset", int'(busy), 0);
        for (int p = 0; p < 5; p++)
            for (int o = 0; o < 5; o++)
                for (int s = 0; s < 7; s++)
                    run_case(offs[o], sizes[s], p);
        // R2 zero size: done right after start with no request
        run_case(48, 0, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule